// File: doc/BRIEF.md
# MMU control register bank

This block keeps the configuration and fault state of a memory-management unit. Software reaches it through a small register port: a 4-bit register index, a 3-bit operation selector and a 32-bit data word, with writes taking effect on the clock edge and reads returned combinationally. Every configuration field goes to the translation logic as its own output. These are the enable bit, the alignment-check bit, the two protection-scheme bits, the aligned table base, the sixteen domain access fields and the lockdown controls.

The translation hardware reports aborts on a separate capture port. A data abort loads the data fault status and the fault address. An instruction abort loads only the instruction fault status. When a capture and a software write hit the same register in the same cycle, the capture wins.

Index 8 stores nothing. A write to it emits a one-cycle TLB maintenance command carrying an opcode and an address. The block does not walk tables, hold TLB entries or check permissions.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: After reset every register reads zero, every configuration output is zero (MMU disabled) and no maintenance command is issued.
- R2: Index 1 holds four bits: enable at bit 0, alignment check at bit 1, protection S at bit 8, protection R at bit 9. Each drives its own output one cycle after the write, and all other bits read zero.
- R3: Index 2 keeps only bits [31:14] as the table base. Bits [13:0] read zero and appear as zero on the base output.
- R4: Index 3 stores a full 32-bit word of sixteen 2-bit domain fields, with domain n at bits [2n+1:2n], and drives it unchanged on the domain output.
- R5: Index 5 selects the data fault status when op2 bit 0 is 0 and the instruction fault status when it is 1. Each keeps bits [7:0] (domain in [7:4], type in [3:0]), and bits [31:8] read zero.
- R6: A data abort loads the data fault status with {domain, type} and index 6 with the abort address. An instruction abort loads only the instruction fault status and leaves index 6 unchanged.
- R7: An abort capture wins over a software write to the same register in the same cycle.
- R8: A write to index 8 with op2 = 0 issues one cycle later a single-cycle command with opcode 0 (invalidate all unpreserved entries). With op2 = 1 it issues opcode 1 (invalidate one entry) carrying the written data as address. Other op2 values issue nothing, and index 8 reads zero.
- R9: Index 10 keeps only bits [28:26] (victim pointer output) and bit 0 (preserve output). All other bits read zero.
- R10: Writes to unmapped indices (0, 4, 7, 9, 11 to 15) change nothing, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_idx_i | input | 4 | Register index |
| reg_op2_i | input | 3 | Operation selector |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| abt_valid_i | input | 1 | Abort capture strobe |
| abt_is_data_i | input | 1 | 1 for data abort, 0 for instruction abort |
| abt_domain_i | input | 4 | Faulting domain number |
| abt_type_i | input | 4 | Fault type code |
| abt_addr_i | input | 32 | Faulting address (data aborts) |
| mmu_en_o | output | 1 | MMU enable |
| align_chk_o | output | 1 | Alignment-check enable |
| prot_s_o | output | 1 | Protection scheme S bit |
| prot_r_o | output | 1 | Protection scheme R bit |
| ttb_o | output | 32 | Table base, low 14 bits zero |
| dom_ac_o | output | 32 | Sixteen 2-bit domain access fields |
| lock_victim_o | output | 3 | Lockdown victim pointer |
| lock_preserve_o | output | 1 | Lockdown preserve bit |
| tlb_cmd_valid_o | output | 1 | Maintenance command pulse |
| tlb_cmd_op_o | output | 1 | 0 invalidate all, 1 invalidate entry |
| tlb_cmd_addr_o | output | 32 | Address for entry invalidation |

## Verification
The assertions check three things on every cycle. A command pulse appears only after a write to index 8 with a valid selector, and such a write always produces the matching opcode and address. The control outputs stay still unless index 1 was written. Abort capture overrides software writes to the fault address and data status, and an instruction abort never disturbs the fault address. The bench scenarios cover the masking of each register's unimplemented bits, the field layout on the domain output, the silence of unmapped indices and of unused selectors, the zero readback of index 8, and the reset state.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = 4;
  localparam int TTB_LSB = 14;
  localparam int FSR_W   = 8;

  localparam logic [IDX_W-1:0] IDX_CTRL = 4'd1;
  localparam logic [IDX_W-1:0] IDX_TTB  = 4'd2;
  localparam logic [IDX_W-1:0] IDX_DOM  = 4'd3;
  localparam logic [IDX_W-1:0] IDX_FSR  = 4'd5;
  localparam logic [IDX_W-1:0] IDX_FAR  = 4'd6;
  localparam logic [IDX_W-1:0] IDX_TLB  = 4'd8;
  localparam logic [IDX_W-1:0] IDX_LOCK = 4'd10;

  localparam int CTRL_M_BIT = 0;
  localparam int CTRL_A_BIT = 1;
  localparam int CTRL_S_BIT = 8;
  localparam int CTRL_R_BIT = 9;

  localparam int LOCK_VIC_LSB = 26;
  localparam int LOCK_VIC_W   = 3;
  localparam int LOCK_P_BIT   = 0;

  typedef enum logic {
    TLB_INV_ALL   = 1'b0,
    TLB_INV_ENTRY = 1'b1
  } tlb_op_e;

  typedef struct packed {
    logic r;
    logic s;
    logic a;
    logic m;
  } ctrl_t;
endpackage

// File: rtl/mmu_cfg_regs.sv
module mmu_cfg_regs
  import mmu_regs_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output ctrl_t                 ctrl_o,
  output logic [DATA_W-1:0]     ttb_o,
  output logic [DATA_W-1:0]     dom_o,
  output logic [LOCK_VIC_W-1:0] lock_vic_o,
  output logic                  lock_p_o
);
  localparam int TTB_W = DATA_W - TTB_LSB;

  ctrl_t                   ctrl_q;
  logic [TTB_W-1:0]        ttb_q;
  logic [DATA_W-1:0]       dom_q;
  logic [LOCK_VIC_W-1:0]   vic_q;
  logic                    lock_p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      ttb_q    <= '0;
      dom_q    <= '0;
      vic_q    <= '0;
      lock_p_q <= 1'b0;
    end else if (wr_i) begin
      unique case (idx_i)
        IDX_CTRL: ctrl_q <= '{r: wdata_i[CTRL_R_BIT], s: wdata_i[CTRL_S_BIT],
                              a: wdata_i[CTRL_A_BIT], m: wdata_i[CTRL_M_BIT]};
        IDX_TTB:  ttb_q  <= wdata_i[DATA_W-1:TTB_LSB];
        IDX_DOM:  dom_q  <= wdata_i;
        IDX_LOCK: begin
          vic_q    <= wdata_i[LOCK_VIC_LSB +: LOCK_VIC_W];
          lock_p_q <= wdata_i[LOCK_P_BIT];
        end
        default: ;
      endcase
    end
  end

  assign ctrl_o     = ctrl_q;
  assign ttb_o      = {ttb_q, {TTB_LSB{1'b0}}};
  assign dom_o      = dom_q;
  assign lock_vic_o = vic_q;
  assign lock_p_o   = lock_p_q;
endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs
  import mmu_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              sel_instr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              abt_valid_i,
  input  logic              abt_is_data_i,
  input  logic [3:0]        abt_domain_i,
  input  logic [3:0]        abt_type_i,
  input  logic [DATA_W-1:0] abt_addr_i,
  output logic [FSR_W-1:0]  dfsr_o,
  output logic [FSR_W-1:0]  ifsr_o,
  output logic [DATA_W-1:0] far_o
);
  logic abt_d, abt_i, sw_fsr, sw_far;

  assign abt_d  = abt_valid_i &&  abt_is_data_i;
  assign abt_i  = abt_valid_i && !abt_is_data_i;
  assign sw_fsr = wr_i && (idx_i == IDX_FSR);
  assign sw_far = wr_i && (idx_i == IDX_FAR);

  // hardware capture has priority over software
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dfsr_o <= '0;
      ifsr_o <= '0;
      far_o  <= '0;
    end else begin
      if (abt_d)                      dfsr_o <= {abt_domain_i, abt_type_i};
      else if (sw_fsr && !sel_instr_i) dfsr_o <= wdata_i[FSR_W-1:0];

      if (abt_i)                      ifsr_o <= {abt_domain_i, abt_type_i};
      else if (sw_fsr && sel_instr_i) ifsr_o <= wdata_i[FSR_W-1:0];

      if (abt_d)       far_o <= abt_addr_i;
      else if (sw_far) far_o <= wdata_i;
    end
  end
endmodule

// File: rtl/mmu_tlb_cmd.sv
module mmu_tlb_cmd
  import mmu_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [2:0]        op2_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              valid_o,
  output tlb_op_e           op_o,
  output logic [DATA_W-1:0] addr_o
);
  logic hit, sel_ok;

  assign hit    = wr_i && (idx_i == IDX_TLB);
  assign sel_ok = (op2_i[2:1] == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      op_o    <= TLB_INV_ALL;
      addr_o  <= '0;
    end else begin
      valid_o <= hit && sel_ok;
      if (hit && sel_ok) begin
        op_o   <= op2_i[0] ? TLB_INV_ENTRY : TLB_INV_ALL;
        addr_o <= op2_i[0] ? wdata_i : '0;
      end
    end
  end
endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
  import mmu_regs_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_wr_i,
  input  logic [IDX_W-1:0]      reg_idx_i,
  input  logic [2:0]            reg_op2_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  input  logic                  abt_valid_i,
  input  logic                  abt_is_data_i,
  input  logic [3:0]            abt_domain_i,
  input  logic [3:0]            abt_type_i,
  input  logic [DATA_W-1:0]     abt_addr_i,
  output logic                  mmu_en_o,
  output logic                  align_chk_o,
  output logic                  prot_s_o,
  output logic                  prot_r_o,
  output logic [DATA_W-1:0]     ttb_o,
  output logic [DATA_W-1:0]     dom_ac_o,
  output logic [LOCK_VIC_W-1:0] lock_victim_o,
  output logic                  lock_preserve_o,
  output logic                  tlb_cmd_valid_o,
  output logic                  tlb_cmd_op_o,
  output logic [DATA_W-1:0]     tlb_cmd_addr_o
);
  ctrl_t             ctrl;
  logic [FSR_W-1:0]  dfsr, ifsr;
  logic [DATA_W-1:0] far;
  tlb_op_e           cmd_op;

  mmu_cfg_regs u_cfg (
    .clk_i, .rst_ni,
    .wr_i       (reg_wr_i),
    .idx_i      (reg_idx_i),
    .wdata_i    (reg_wdata_i),
    .ctrl_o     (ctrl),
    .ttb_o      (ttb_o),
    .dom_o      (dom_ac_o),
    .lock_vic_o (lock_victim_o),
    .lock_p_o   (lock_preserve_o)
  );

  mmu_fault_regs u_fault (
    .clk_i, .rst_ni,
    .wr_i          (reg_wr_i),
    .idx_i         (reg_idx_i),
    .sel_instr_i   (reg_op2_i[0]),
    .wdata_i       (reg_wdata_i),
    .abt_valid_i, .abt_is_data_i, .abt_domain_i, .abt_type_i, .abt_addr_i,
    .dfsr_o        (dfsr),
    .ifsr_o        (ifsr),
    .far_o         (far)
  );

  mmu_tlb_cmd u_tlb (
    .clk_i, .rst_ni,
    .wr_i    (reg_wr_i),
    .idx_i   (reg_idx_i),
    .op2_i   (reg_op2_i),
    .wdata_i (reg_wdata_i),
    .valid_o (tlb_cmd_valid_o),
    .op_o    (cmd_op),
    .addr_o  (tlb_cmd_addr_o)
  );

  assign tlb_cmd_op_o = cmd_op;
  assign mmu_en_o     = ctrl.m;
  assign align_chk_o  = ctrl.a;
  assign prot_s_o     = ctrl.s;
  assign prot_r_o     = ctrl.r;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_idx_i)
      IDX_CTRL: begin
        reg_rdata_o[CTRL_M_BIT] = ctrl.m;
        reg_rdata_o[CTRL_A_BIT] = ctrl.a;
        reg_rdata_o[CTRL_S_BIT] = ctrl.s;
        reg_rdata_o[CTRL_R_BIT] = ctrl.r;
      end
      IDX_TTB:  reg_rdata_o = ttb_o;
      IDX_DOM:  reg_rdata_o = dom_ac_o;
      IDX_FSR:  reg_rdata_o[FSR_W-1:0] = reg_op2_i[0] ? ifsr : dfsr;
      IDX_FAR:  reg_rdata_o = far;
      IDX_LOCK: begin
        reg_rdata_o[LOCK_VIC_LSB +: LOCK_VIC_W] = lock_victim_o;
        reg_rdata_o[LOCK_P_BIT]                 = lock_preserve_o;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mmu_ctrl_regs_chk.sv
module mmu_ctrl_regs_chk
  import mmu_regs_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [IDX_W-1:0]  reg_idx_i,
  input logic [2:0]        reg_op2_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              abt_valid_i,
  input logic              abt_is_data_i,
  input logic [3:0]        abt_domain_i,
  input logic [3:0]        abt_type_i,
  input logic [DATA_W-1:0] abt_addr_i,
  input logic              mmu_en_o,
  input logic              align_chk_o,
  input logic              tlb_cmd_valid_o,
  input logic              tlb_cmd_op_o,
  input logic [DATA_W-1:0] tlb_cmd_addr_o,
  input logic [FSR_W-1:0]  dfsr,
  input logic [DATA_W-1:0] far
);
  AST_CMD_ONLY_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_cmd_valid_o |-> $past(reg_wr_i && reg_idx_i == IDX_TLB && reg_op2_i[2:1] == 2'b00)); // R8

  AST_CMD_INV_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_idx_i == IDX_TLB && reg_op2_i == 3'd1) |=>
      (tlb_cmd_valid_o && tlb_cmd_op_o && tlb_cmd_addr_o == $past(reg_wdata_i))); // R8

  AST_CMD_INV_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_idx_i == IDX_TLB && reg_op2_i == 3'd0) |=>
      (tlb_cmd_valid_o && !tlb_cmd_op_o)); // R8

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_idx_i == IDX_CTRL) |=> ($stable(mmu_en_o) && $stable(align_chk_o))); // R2

  AST_DABT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abt_valid_i && abt_is_data_i) |=>
      (far == $past(abt_addr_i) && dfsr == $past({abt_domain_i, abt_type_i}))); // R7

  AST_IABT_FAR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abt_valid_i && !abt_is_data_i && !(reg_wr_i && reg_idx_i == IDX_FAR)) |=> $stable(far)); // R6
endmodule

bind mmu_ctrl_regs mmu_ctrl_regs_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reg_wr_i        (reg_wr_i),
  .reg_idx_i       (reg_idx_i),
  .reg_op2_i       (reg_op2_i),
  .reg_wdata_i     (reg_wdata_i),
  .abt_valid_i     (abt_valid_i),
  .abt_is_data_i   (abt_is_data_i),
  .abt_domain_i    (abt_domain_i),
  .abt_type_i      (abt_type_i),
  .abt_addr_i      (abt_addr_i),
  .mmu_en_o        (mmu_en_o),
  .align_chk_o     (align_chk_o),
  .tlb_cmd_valid_o (tlb_cmd_valid_o),
  .tlb_cmd_op_o    (tlb_cmd_op_o),
  .tlb_cmd_addr_o  (tlb_cmd_addr_o),
  .dfsr            (dfsr),
  .far             (far)
);

// File: tb/tb_mmu_ctrl_regs.sv
module tb_mmu_ctrl_regs;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]  idx;
    logic [2:0]  op2;
    logic [31:0] wdata;
    logic [31:0] expect_rd;
  } vec_t;

  // write then read back at the same index and selector
  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{4'd1,  3'd0, 32'hFFFF_FFFF, 32'h0000_0303},  // R2
    '{4'd2,  3'd0, 32'hFFFF_FFFF, 32'hFFFF_C000},  // R3
    '{4'd3,  3'd0, 32'hA5A5_1234, 32'hA5A5_1234},  // R4
    '{4'd5,  3'd0, 32'hFFFF_FFAB, 32'h0000_00AB},  // R5 data
    '{4'd5,  3'd1, 32'h1234_56CD, 32'h0000_00CD},  // R5 instr
    '{4'd6,  3'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R6 sw path
    '{4'd10, 3'd0, 32'hFFFF_FFFF, 32'h1C00_0001},  // R9
    '{4'd8,  3'd1, 32'h1234_5678, 32'h0000_0000},  // R8 readback
    '{4'd0,  3'd0, 32'hFFFF_FFFF, 32'h0000_0000},  // R10
    '{4'd4,  3'd0, 32'hFFFF_FFFF, 32'h0000_0000},  // R10
    '{4'd15, 3'd0, 32'hFFFF_FFFF, 32'h0000_0000}   // R10
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [3:0]  reg_idx_i = '0;
  logic [2:0]  reg_op2_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        abt_valid_i = 1'b0, abt_is_data_i = 1'b0;
  logic [3:0]  abt_domain_i = '0, abt_type_i = '0;
  logic [31:0] abt_addr_i = '0;
  logic        mmu_en_o, align_chk_o, prot_s_o, prot_r_o;
  logic [31:0] ttb_o, dom_ac_o, tlb_cmd_addr_o;
  logic [2:0]  lock_victim_o;
  logic        lock_preserve_o, tlb_cmd_valid_o, tlb_cmd_op_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mmu_ctrl_regs dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge; register state visible at the next negedge
  task automatic wr(input logic [3:0] idx, input logic [2:0] op2, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_idx_i = idx; reg_op2_i = op2; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, input logic [2:0] op2, output logic [31:0] d);
    reg_idx_i = idx; reg_op2_i = op2;
    #1 d = reg_rdata_o;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    #(CLK_PERIOD * 2 + 3);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int i = 0; i < 16; i++) begin
      rd(i[3:0], 3'd0, r);
      check("R1 rdata", r, 32'h0);
    end
    check("R1 outputs", {mmu_en_o, align_chk_o, prot_s_o, prot_r_o, lock_preserve_o,
                         tlb_cmd_valid_o, lock_victim_o}, 32'h0);
    check("R1 ttb", ttb_o, 32'h0);
    check("R1 dom", dom_ac_o, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i].idx, VECS[i].op2, VECS[i].wdata);
      rd(VECS[i].idx, VECS[i].op2, r);
      check($sformatf("vector %0d (R2/R3/R4/R5/R6/R8/R9/R10)", i), r, VECS[i].expect_rd);
    end

    // decoded outputs
    check("R2 outputs", {28'h0, prot_r_o, prot_s_o, align_chk_o, mmu_en_o}, 32'hF);
    check("R3 ttb_o", ttb_o, 32'hFFFF_C000);
    check("R4 dom_ac_o", dom_ac_o, 32'hA5A5_1234);
    check("R4 domain 15 field", {30'h0, dom_ac_o[31:30]}, 32'h2);
    check("R9 lock outputs", {28'h0, lock_victim_o, lock_preserve_o}, 32'hF);
    rd(4'd5, 3'd0, r);
    check("R5 data fsr kept after instr write", r, 32'hAB);

    // R10 unmapped writes left all mapped state unchanged
    rd(4'd6, 3'd0, r);
    check("R10 far unchanged", r, 32'hDEAD_BEEF);
    rd(4'd3, 3'd0, r);
    check("R10 dom unchanged", r, 32'hA5A5_1234);

    // R2 partial clear
    wr(4'd1, 3'd0, 32'h0000_0100);
    check("R2 only S set", {28'h0, prot_r_o, prot_s_o, align_chk_o, mmu_en_o}, 32'h4);

    // R8 invalidate entry pulse
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_idx_i = 4'd8; reg_op2_i = 3'd1; reg_wdata_i = 32'hCAFE_0000;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
    check("R8 entry valid", {31'h0, tlb_cmd_valid_o}, 32'h1);
    check("R8 entry op", {31'h0, tlb_cmd_op_o}, 32'h1);
    check("R8 entry addr", tlb_cmd_addr_o, 32'hCAFE_0000);
    @(negedge clk_i);
    check("R8 single cycle", {31'h0, tlb_cmd_valid_o}, 32'h0);

    // R8 invalidate all
    wr(4'd8, 3'd0, 32'h5555_5555);
    check("R8 all valid", {31'h0, tlb_cmd_valid_o}, 32'h1);
    check("R8 all op", {31'h0, tlb_cmd_op_o}, 32'h0);

    // R8 unused selector
    wr(4'd8, 3'd5, 32'h1);
    check("R8 op2=5 no cmd", {31'h0, tlb_cmd_valid_o}, 32'h0);

    // R6 data abort
    @(negedge clk_i);
    abt_valid_i = 1'b1; abt_is_data_i = 1'b1; abt_domain_i = 4'hC; abt_type_i = 4'h5;
    abt_addr_i = 32'h8000_1234;
    @(negedge clk_i);
    abt_valid_i = 1'b0;
    rd(4'd5, 3'd0, r); check("R6 dfsr", r, 32'hC5);
    rd(4'd6, 3'd0, r); check("R6 far", r, 32'h8000_1234);
    rd(4'd5, 3'd1, r); check("R6 ifsr untouched", r, 32'hCD);

    // R6 instruction abort
    @(negedge clk_i);
    abt_valid_i = 1'b1; abt_is_data_i = 1'b0; abt_domain_i = 4'h3; abt_type_i = 4'hD;
    abt_addr_i = 32'h0BAD_0BAD;
    @(negedge clk_i);
    abt_valid_i = 1'b0;
    rd(4'd5, 3'd1, r); check("R6 ifsr", r, 32'h3D);
    rd(4'd6, 3'd0, r); check("R6 far kept on instr abort", r, 32'h8000_1234);
    rd(4'd5, 3'd0, r); check("R6 dfsr kept on instr abort", r, 32'hC5);

    // R7 collision on far
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_idx_i = 4'd6; reg_wdata_i = 32'h1111_1111;
    abt_valid_i = 1'b1; abt_is_data_i = 1'b1; abt_domain_i = 4'h7; abt_type_i = 4'h1;
    abt_addr_i = 32'h2222_2222;
    @(negedge clk_i);
    reg_wr_i = 1'b0; abt_valid_i = 1'b0;
    rd(4'd6, 3'd0, r); check("R7 far capture wins", r, 32'h2222_2222);

    // R7 collision on instruction status
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_idx_i = 4'd5; reg_op2_i = 3'd1; reg_wdata_i = 32'hEE;
    abt_valid_i = 1'b1; abt_is_data_i = 1'b0; abt_domain_i = 4'h9; abt_type_i = 4'h6;
    @(negedge clk_i);
    reg_wr_i = 1'b0; abt_valid_i = 1'b0;
    rd(4'd5, 3'd1, r); check("R7 ifsr capture wins", r, 32'h96);

    // R1 reset again
    rst_ni = 1'b0;
    #1;
    check("R1 reset clears en", {31'h0, mmu_en_o}, 32'h0);
    rd(4'd6, 3'd0, r); check("R1 reset clears far", r, 32'h0);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule